// File: doc/BRIEF.md
# Flash ADC Thermometer Encoder

This block sits behind the clocked comparator bank of a flash converter. It turns a 256-bit thermometer vector into a registered 8-bit output word, an overrange flag and a data-valid strobe. The vector is cut into four columns of 64 comparators. Each column finds its own top edge and reports a 6-bit position and a hit flag. These column results are latched on the falling clock edge. On the next rising edge the highest hit column supplies the two upper bits, and its position supplies the six lower bits.

Each code position is decided by a three-way neighbour vote over the comparator outputs. A lone comparator that disagrees with both of its neighbours is outvoted, so a single misplaced comparator moves the word by at most one code. Two static controls, sampled together with the comparator vector, flip the upper bit and the lower seven bits independently. This gives four output codings: straight binary, two's complement, inverted two's complement and inverted binary. When the topmost comparator fires, the word is forced to all ones and the overrange flag rises. A polarity input sets the active level of the data-valid strobe.

Top module: `flash_therm_enc`

## Requirements
- R1: With comparator 255 low, both inversion controls low and comparators 0..n-1 high (all others low), data_o equals n in straight binary. n=0 gives 8'h00 and n=255 gives 8'hFF.
- R2: A comparator vector sampled on rising edge k drives data_o and ovr_o right after rising edge k+1. Back-to-back vectors each appear in their own cycle.
- R3: A clean thermometer of n ones with a single comparator in 0..254 flipped produces a code within one of n, and ovr_o stays low.
- R4: inv_msb_i high inverts data bit 7 only, relative to the straight-binary code.
- R5: inv_lsb_i high inverts data bits 6..0 only, relative to the straight-binary code. Both controls are sampled with the same edge as the comparator vector.
- R6: Comparator 255 high sets ovr_o and forces data_o to 8'hFF, whatever the inversion controls are.
- R7: rdy_o equals rdy_pol_i while no valid word has been produced since reset. From the second rising edge after reset release, rdy_o equals the inverse of rdy_pol_i.
- R8: While rst_ni is low, data_o is 8'h00 and ovr_o is 0.
- R9: The two upper bits of a clean in-range code equal n/64 and the six lower bits equal n mod 64, including at the column edges n = 63, 64, 127, 128, 191 and 192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| therm_i | input | 256 | Comparator outputs; bit i high when the input is above tap i |
| inv_msb_i | input | 1 | Invert the upper output bit |
| inv_lsb_i | input | 1 | Invert the lower seven output bits |
| rdy_pol_i | input | 1 | Active level of rdy_o is the inverse of this input |
| data_o | output | 8 | Registered output code |
| ovr_o | output | 1 | Overrange flag |
| rdy_o | output | 1 | Data-valid strobe |

## Verification
A comparator vector and its inversion settings are driven together, shortly after one rising edge. Their result is due right after the second rising edge that follows. The bench keeps a two-deep record of what it drove and compares each output against the entry from two steps back, sampling 1 ns after the edge. Back-to-back random vectors therefore prove the latency as well as the coding. The strobe is checked at the first and second edges after reset release, to catch a valid indication that arrives one cycle early. The polarity input acts without a register, so the bench checks its effect 1 ns after changing it.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  localparam int unsigned DEF_COLS  = 4;
  localparam int unsigned DEF_COL_W = 64;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/therm_col_enc.sv
module therm_col_enc
  import flash_enc_pkg::*;
#(
  parameter int unsigned COL_W = 64,
  parameter int unsigned POS_W = $clog2(COL_W)
) (
  input  logic [COL_W-1:0] seg_i,
  input  logic             below_i,
  input  logic             above_i,
  output logic             hit_o,
  output logic [POS_W-1:0] pos_o
);
  logic [COL_W+1:0] ext;
  logic [COL_W-1:0] vote;

  assign ext = {above_i, seg_i, below_i};

  // neighbour vote outvotes a lone flipped comparator
  for (genvar j = 0; j < COL_W; j++) begin : g_vote
    assign vote[j] = maj3(ext[j], ext[j+1], ext[j+2]);
  end

  assign hit_o = |vote;

  always_comb begin
    pos_o = '0;
    for (int j = 0; j < COL_W; j++) begin
      if (vote[j]) pos_o = POS_W'(j);
    end
  end
endmodule

// File: rtl/col_merge.sv
module col_merge #(
  parameter int unsigned NUM_COLS = 4,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned SEL_W    = $clog2(NUM_COLS),
  parameter int unsigned DW       = SEL_W + POS_W
) (
  input  logic [NUM_COLS-1:0]       hit_i,
  input  logic [NUM_COLS*POS_W-1:0] pos_i,
  output logic [DW-1:0]             code_o
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int g = 0; g < NUM_COLS; g++) begin
      if (hit_i[g]) sel = SEL_W'(g);
    end
  end

  assign code_o = {sel, pos_i[sel*POS_W +: POS_W]};
endmodule

// File: rtl/code_fmt.sv
module code_fmt #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] code_i,
  input  logic          ovr_i,
  input  logic          inv_msb_i,
  input  logic          inv_lsb_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] mask;

  assign mask   = {inv_msb_i, {(DW-1){inv_lsb_i}}};
  assign data_o = ovr_i ? '1 : (code_i ^ mask);
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import flash_enc_pkg::*;
#(
  parameter int unsigned NUM_COLS = DEF_COLS,
  parameter int unsigned COL_W    = DEF_COL_W,
  parameter int unsigned N_CMP    = NUM_COLS * COL_W,
  parameter int unsigned DW       = $clog2(N_CMP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] therm_i,
  input  logic             inv_msb_i,
  input  logic             inv_lsb_i,
  input  logic             rdy_pol_i,
  output logic [DW-1:0]    data_o,
  output logic             ovr_o,
  output logic             rdy_o
);
  localparam int unsigned POS_W = $clog2(COL_W);
  localparam int unsigned SEL_W = $clog2(NUM_COLS);

  // rising-edge comparator latch
  logic [N_CMP-1:0] cmp_q;
  logic             im_cap_q, il_cap_q, vld_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q     <= '0;
      im_cap_q  <= 1'b0;
      il_cap_q  <= 1'b0;
      vld_cap_q <= 1'b0;
    end else begin
      cmp_q     <= therm_i;
      im_cap_q  <= inv_msb_i;
      il_cap_q  <= inv_lsb_i;
      vld_cap_q <= 1'b1;
    end
  end

  // code position p is set when comparator p-1 is high; position 0 is ground
  logic [N_CMP-1:0] lvl;
  assign lvl = {cmp_q[N_CMP-2:0], 1'b1};

  logic [NUM_COLS-1:0]       hit;
  logic [NUM_COLS*POS_W-1:0] pos;

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_col
    logic below, above;
    if (g == 0) begin : g_lo
      assign below = 1'b1;
    end else begin : g_lo
      assign below = lvl[g*COL_W-1];
    end
    if (g == NUM_COLS-1) begin : g_hi
      assign above = 1'b0;
    end else begin : g_hi
      assign above = lvl[(g+1)*COL_W];
    end

    therm_col_enc #(.COL_W(COL_W), .POS_W(POS_W)) i_col (
      .seg_i   (lvl[g*COL_W +: COL_W]),
      .below_i (below),
      .above_i (above),
      .hit_o   (hit[g]),
      .pos_o   (pos[g*POS_W +: POS_W])
    );
  end

  // falling-edge column latches
  logic [NUM_COLS-1:0]       hit_q;
  logic [NUM_COLS*POS_W-1:0] pos_q;
  logic                      ovr_mid_q, im_mid_q, il_mid_q, vld_mid_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q     <= '0;
      pos_q     <= '0;
      ovr_mid_q <= 1'b0;
      im_mid_q  <= 1'b0;
      il_mid_q  <= 1'b0;
      vld_mid_q <= 1'b0;
    end else begin
      hit_q     <= hit;
      pos_q     <= pos;
      ovr_mid_q <= cmp_q[N_CMP-1];
      im_mid_q  <= im_cap_q;
      il_mid_q  <= il_cap_q;
      vld_mid_q <= vld_cap_q;
    end
  end

  logic [DW-1:0] code, word;

  col_merge #(.NUM_COLS(NUM_COLS), .POS_W(POS_W), .SEL_W(SEL_W), .DW(DW)) i_merge (
    .hit_i  (hit_q),
    .pos_i  (pos_q),
    .code_o (code)
  );

  code_fmt #(.DW(DW)) i_fmt (
    .code_i    (code),
    .ovr_i     (ovr_mid_q),
    .inv_msb_i (im_mid_q),
    .inv_lsb_i (il_mid_q),
    .data_o    (word)
  );

  // rising-edge output register
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      data_o <= word;
      ovr_o  <= ovr_mid_q;
      vld_q  <= vld_mid_q;
    end
  end

  assign rdy_o = vld_q ^ rdy_pol_i;
endmodule

// File: rtl/flash_therm_enc_chk.sv
module flash_therm_enc_chk #(
  parameter int unsigned N_CMP = 256,
  parameter int unsigned DW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CMP-1:0] therm_i,
  input logic             inv_msb_i,
  input logic             inv_lsb_i,
  input logic             rdy_pol_i,
  input logic [DW-1:0]    data_o,
  input logic             ovr_o,
  input logic             rdy_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_OVR_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> data_o == '1); // R6

  AST_OVR_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q >= 2'd2 |-> ovr_o == $past(therm_i[N_CMP-1], 2)); // R6

  AST_RDY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q >= 2'd2 |-> rdy_o != rdy_pol_i); // R7

  AST_EMPTY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && $past(therm_i, 2) == '0) |->
      data_o == {$past(inv_msb_i, 2), {(DW-1){$past(inv_lsb_i, 2)}}}); // R4

  AST_FULL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && $past(therm_i, 2) == {1'b0, {(N_CMP-1){1'b1}}}) |->
      data_o == ~{$past(inv_msb_i, 2), {(DW-1){$past(inv_lsb_i, 2)}}}); // R5
endmodule

bind flash_therm_enc flash_therm_enc_chk #(.N_CMP(N_CMP), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .therm_i   (therm_i),
  .inv_msb_i (inv_msb_i),
  .inv_lsb_i (inv_lsb_i),
  .rdy_pol_i (rdy_pol_i),
  .data_o    (data_o),
  .ovr_o     (ovr_o),
  .rdy_o     (rdy_o)
);

// File: tb/test_flash_therm_enc.sv
module test_flash_therm_enc;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [255:0] therm_i = '0;
  logic         inv_msb_i = 1'b0, inv_lsb_i = 1'b0, rdy_pol_i = 1'b0;
  logic [7:0]   data_o;
  logic         ovr_o, rdy_o;

  int n_chk = 0, n_fail = 0, since_rst = 0;

  // two-deep record of driven stimulus
  logic [255:0] e_vec1, e_vec2;
  int           e_n1, e_n2;
  bit           e_im1, e_im2, e_il1, e_il2, e_tol1, e_tol2, e_v1 = 0, e_v2 = 0;
  string        e_tag1, e_tag2;

  always #2.5 clk_i = ~clk_i;

  flash_therm_enc i_flash_therm_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .therm_i(therm_i),
    .inv_msb_i(inv_msb_i), .inv_lsb_i(inv_lsb_i), .rdy_pol_i(rdy_pol_i),
    .data_o(data_o), .ovr_o(ovr_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] therm(input int n);
    logic [255:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic evaluate();
    logic [7:0] mask, raw;
    int diff;
    mask = {e_im2, {7{e_il2}}};
    if (e_vec2[255]) begin
      chk({e_tag2, " ovr data"}, data_o, 255);
      chk({e_tag2, " ovr flag"}, ovr_o, 1);
    end else if (e_tol2) begin
      raw  = data_o ^ mask;
      diff = int'(raw) - e_n2;
      if (diff < -1 || diff > 1) chk({e_tag2, " sparkle"}, raw, e_n2);
      else                       chk({e_tag2, " sparkle"}, 0, 0);
      chk({e_tag2, " sparkle ovr"}, ovr_o, 0);
    end else begin
      chk({e_tag2, " data"}, data_o, int'(8'(e_n2) ^ mask));
      chk({e_tag2, " ovr"}, ovr_o, 0);
    end
  endtask

  task automatic step(input logic [255:0] v, input int n, input bit im, input bit il,
                      input bit tol, input string tag);
    @(posedge clk_i); #1;
    since_rst++;
    if (since_rst == 1) chk("R7 not yet valid", rdy_o, rdy_pol_i);
    if (since_rst == 2) chk("R7 valid", rdy_o, !rdy_pol_i);
    if (e_v2) evaluate();
    e_vec2 = e_vec1; e_n2 = e_n1; e_im2 = e_im1; e_il2 = e_il1;
    e_tol2 = e_tol1; e_tag2 = e_tag1; e_v2 = e_v1;
    e_vec1 = v; e_n1 = n; e_im1 = im; e_il1 = il; e_tol1 = tol; e_tag1 = tag; e_v1 = 1;
    therm_i = v; inv_msb_i = im; inv_lsb_i = il;
  endtask

  task automatic clean(input int n, input bit im, input bit il, input string tag);
    step(therm(n), n, im, il, 0, tag);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] v;
    int n, p, bnd[7];
    bit im, il;
    void'($urandom(32'd20240611));
    bnd = '{63, 64, 65, 127, 128, 191, 192};

    therm_i = therm(200);
    inv_msb_i = 1; inv_lsb_i = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 reset data", data_o, 0);
    chk("R8 reset ovr", ovr_o, 0);
    chk("R7 reset rdy", rdy_o, 0);
    rdy_pol_i = 1; #1;
    chk("R7 reset rdy inverted", rdy_o, 1);
    rdy_pol_i = 0;
    inv_msb_i = 0; inv_lsb_i = 0;
    rst_ni = 1'b1;

    // R1 R2: extremes back to back
    clean(0, 0, 0, "R1 zero");
    clean(255, 0, 0, "R1 full");
    clean(0, 0, 0, "R2 alt");
    clean(255, 0, 0, "R2 alt");
    clean(1, 0, 0, "R2 alt");
    // R9 column edges
    foreach (bnd[i]) clean(bnd[i], 0, 0, "R9 edge");
    // R4 R5 inversion combos
    clean(100, 1, 0, "R4 msb inv");
    clean(200, 1, 0, "R4 msb inv");
    clean(100, 0, 1, "R5 lsb inv");
    clean(200, 0, 1, "R5 lsb inv");
    clean(37, 1, 1, "R4 R5 both inv");
    clean(0, 1, 1, "R4 R5 both inv");
    // R6 overrange under every coding
    for (int k = 0; k < 4; k++) begin
      v = therm(255); v[255] = 1'b1;
      step(v, 256, k[1], k[0], 0, "R6 overrange");
    end
    v = '0; v[255] = 1'b1;
    step(v, 256, 0, 1, 0, "R6 lone top");
    // R3 directed sparkles around the edge and at column seams
    foreach (bnd[i]) begin
      n = bnd[i];
      for (int d = -1; d <= 2; d++) begin
        v = therm(n); v[n+d] = ~v[n+d];
        step(v, n, 0, 0, 1, "R3 sparkle");
      end
    end
    v = therm(0); v[0] = 1'b1;   step(v, 0, 0, 0, 1, "R3 low end");
    v = therm(254); v[254] = 1'b1; step(v, 254, 0, 0, 1, "R3 high end");

    // random mix
    for (int i = 0; i < 600; i++) begin
      n  = $urandom_range(0, 255);
      im = 1'($urandom_range(0, 1));
      il = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 7))
        0: begin
          v = therm(n); v[255] = 1'b1;
          step(v, 256, im, il, 0, "R6 random");
        end
        1, 2, 3: begin
          p = $urandom_range(0, 254);
          v = therm(n); v[p] = ~v[p];
          step(v, n, im, il, 1, "R3 random");
        end
        default: clean(n, im, il, (im || il) ? "R5 random coded" : "R1 random");
      endcase
    end
    clean(0, 0, 0, "R1 flush");
    clean(0, 0, 0, "R1 flush");
    clean(0, 0, 0, "R1 flush");

    rdy_pol_i = 1; #1;
    chk("R7 polarity flipped", rdy_o, 0);
    rdy_pol_i = 0; #1;
    chk("R7 polarity restored", rdy_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule